// File: doc/BRIEF.md
# NAND Flash Identification and Geometry Decoder

The block runs the bring-up of a raw NAND device over a cycle-level command, address and data bus. A `start_i` pulse begins the probe. The block issues a reset command and waits for the ready/busy line to return high, then reads the ID bytes. From the device code and a small internal table of known devices it works out the bus width, page size, erase-block size, address-cycle count and block count. These results are held on output registers until the next probe. The valid flag and the error flag can never be high together.

When a table entry leaves page size or erase size open, the block reads three more ID bytes and decodes the missing geometry from the second of them. The probe fails with an error code in three cases: the ready line never returns, the device code is not in the table, or the table marks the device as having 256-byte pages. An unknown maker code does not stop the probe. It is reported through a "maker known" flag that is held low.

Top module: `nand_id_probe`

## Requirements
- R1: A probe drives these bus cycles in order, one per clock: a command cycle 0xFF; a wait until `rb_ni` reads high, at least one cycle after that command; a command cycle 0x90; one address cycle 0x00; a read strobe for the maker byte; a read strobe for the device byte. Command cycles use `cle_o`, address cycles use `ale_o` and read strobes use `re_o`, and at most one of the three is high in any cycle.
- R2: The maker byte and the device byte are always taken from `io_i[7:0]`. The upper half of a 16-bit word is dropped.
- R3: If the table entry gives no page size or no erase size, exactly three more read strobes follow, capturing ID bytes 3, 4 and 5. With `wide_bus_i`=1, byte 5 is `io_i[15:8]` of the third word; otherwise every byte is `io_i[7:0]`. `ext_id_o` = {byte5, byte4, byte3}. It is zero when no extra bytes are read.
- R4: When the page size is decoded from the extra bytes, it equals 1 << (10 + byte4[1:0]) bytes.
- R5: When the erase size is decoded from the extra bytes, it equals 64 KiB << byte4[5:4].
- R6: A table page size of 256 bytes ends the probe with `err_o`=1 and `err_code_o`=3.
- R7: Pages of 512 bytes or less give 3 address cycles for chips up to 32 MiB, 4 cycles up to 8192 MiB, and 5 cycles above that.
- R8: Larger pages give 4 address cycles for chips up to 128 MiB, 5 cycles up to 32768 MiB, and 6 cycles above that.
- R9: `block_count_o` equals the chip size in KiB divided by the erase size in KiB.
- R10: A device code that is not in the table ends the probe with `err_o`=1 and `err_code_o`=2. A maker code outside {0x98, 0xEC, 0x04, 0x8F, 0x07, 0x20, 0xAD} still completes the probe, with `maker_known_o`=0.
- R11: If `rb_ni` is still low READY_TIMEOUT cycles after the reset command, the probe ends with `err_o`=1 and `err_code_o`=1, and no ID command is issued.
- R12: The table maps each code to (size MiB, page bytes, erase KiB, 16-bit flag), where 0 means "decode from the extra bytes":
  - 0x6E: (1, 256, 4, 0)
  - 0x6B: (4, 512, 8, 0)
  - 0x73: (16, 512, 16, 0)
  - 0x75: (32, 512, 16, 0)
  - 0x56: (64, 512, 16, 1)
  - 0x79: (128, 512, 16, 0)
  - 0xF1: (128, 0, 0, 0)
  - 0xDA: (256, 0, 0, 0)
  - 0xCA: (256, 0, 0, 1)

  `bus16_o` carries the 16-bit flag.
- R13: `valid_o` rises 3 cycles after the cycle that holds the device-byte strobe, or 2 cycles after the cycle that holds the byte-5 strobe. `err_o` for a code-related error rises 3 cycles after the device-byte strobe. Both flags clear when a new probe starts, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a probe when the block is idle |
| wide_bus_i | input | 1 | ID reads use a 16-bit data bus |
| rb_ni | input | 1 | Device ready (high) or busy (low) |
| io_i | input | 16 | Read data from the device |
| cle_o | output | 1 | Command cycle strobe |
| ale_o | output | 1 | Address cycle strobe |
| re_o | output | 1 | Read strobe, data sampled at the next edge |
| io_o | output | 8 | Command or address byte |
| busy_o | output | 1 | A probe is in progress |
| valid_o | output | 1 | Geometry outputs are valid |
| err_o | output | 1 | Probe failed |
| err_code_o | output | 2 | 0 none, 1 ready timeout, 2 unknown device, 3 unsupported page |
| maker_id_o | output | 8 | Captured maker byte |
| maker_known_o | output | 1 | Maker code is in the known list |
| dev_id_o | output | 8 | Captured device byte |
| ext_id_o | output | 24 | Extra ID bytes {5,4,3} |
| bus16_o | output | 1 | Device has a 16-bit bus |
| page_size_o | output | 14 | Page size in bytes |
| erase_kib_o | output | 10 | Erase block size in KiB |
| addr_cycles_o | output | 3 | Address cycle count |
| block_count_o | output | 20 | Number of erase blocks |

## Verification
Each result is due at a fixed number of cycles after the last read strobe: a finished probe with no extra bytes raises `valid_o` 3 cycles after the device-byte strobe, and a probe with extra bytes raises it 2 cycles after the byte-5 strobe. Errors from the device code are flagged 3 cycles after the device-byte strobe. The bench's device model stamps the cycle of every strobe. The scoreboard item carries the expected delay, and the monitor compares it with the cycle in which it first sees the flag, sampling on the falling clock edge. The bus order and the number of strobes are checked against the model's log after every probe.

// File: rtl/nand_probe_pkg.sv
package nand_probe_pkg;

  localparam int unsigned SIZE_W = 16;
  localparam logic [7:0] CMD_RESET   = 8'hFF;
  localparam logic [7:0] CMD_READ_ID = 8'h90;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_UNKNOWN = 2'd2,
    ERR_PAGE    = 2'd3
  } err_e;

  // page_lg2 / erase_lg2 (KiB) of zero: decode from extra ID bytes
  typedef struct packed {
    logic              hit;
    logic [SIZE_W-1:0] size_mib;
    logic [3:0]        page_lg2;
    logic [3:0]        erase_lg2;
    logic              wide;
  } dev_entry_t;

  function automatic dev_entry_t lookup_dev(input logic [7:0] code);
    dev_entry_t e;
    case (code)
      8'h6E:   e = '{1'b1, 16'd1,   4'd8, 4'd2, 1'b0};
      8'h6B:   e = '{1'b1, 16'd4,   4'd9, 4'd3, 1'b0};
      8'h73:   e = '{1'b1, 16'd16,  4'd9, 4'd4, 1'b0};
      8'h75:   e = '{1'b1, 16'd32,  4'd9, 4'd4, 1'b0};
      8'h56:   e = '{1'b1, 16'd64,  4'd9, 4'd4, 1'b1};
      8'h79:   e = '{1'b1, 16'd128, 4'd9, 4'd4, 1'b0};
      8'hF1:   e = '{1'b1, 16'd128, 4'd0, 4'd0, 1'b0};
      8'hDA:   e = '{1'b1, 16'd256, 4'd0, 4'd0, 1'b0};
      8'hCA:   e = '{1'b1, 16'd256, 4'd0, 4'd0, 1'b1};
      default: e = '0;
    endcase
    return e;
  endfunction

  function automatic logic maker_known(input logic [7:0] code);
    case (code)
      8'h98, 8'hEC, 8'h04, 8'h8F, 8'h07, 8'h20, 8'hAD: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/nand_geom_calc.sv
module nand_geom_calc
  import nand_probe_pkg::*;
#(
  parameter int unsigned BLK_W = 20
) (
  input  logic [7:0]       dev_id_i,
  input  logic [7:0]       id4_i,
  output logic             known_o,
  output logic             need_ext_o,
  output logic             page_bad_o,
  output logic             wide_o,
  output logic [3:0]       page_lg2_o,
  output logic [3:0]       erase_lg2_o,
  output logic [2:0]       addr_cycles_o,
  output logic [BLK_W-1:0] block_count_o
);
  localparam int unsigned KIB_W = SIZE_W + 10;

  dev_entry_t       ent;
  logic             small_page;
  logic [KIB_W-1:0] chip_kib;
  logic [KIB_W-1:0] blocks_full;

  always_comb begin
    ent         = lookup_dev(dev_id_i);
    known_o     = ent.hit;
    wide_o      = ent.wide;
    need_ext_o  = ent.hit && (ent.page_lg2 == 4'd0 || ent.erase_lg2 == 4'd0);
    page_bad_o  = ent.hit && (ent.page_lg2 == 4'd8);
    page_lg2_o  = (ent.page_lg2 == 4'd0) ? 4'd10 + {2'b00, id4_i[1:0]} : ent.page_lg2;
    erase_lg2_o = (ent.erase_lg2 == 4'd0) ? 4'd6 + {2'b00, id4_i[5:4]} : ent.erase_lg2;
    small_page  = page_lg2_o <= 4'd9;
    if (small_page)
      addr_cycles_o = (ent.size_mib <= 16'd32)   ? 3'd3 :
                      (ent.size_mib <= 16'd8192) ? 3'd4 : 3'd5;
    else
      addr_cycles_o = (ent.size_mib <= 16'd128)   ? 3'd4 :
                      (ent.size_mib <= 16'd32768) ? 3'd5 : 3'd6;
    chip_kib      = {ent.size_mib, 10'b0};
    blocks_full   = chip_kib >> erase_lg2_o;
    block_count_o = blocks_full[BLK_W-1:0];
  end

  always_comb begin
    if (known_o) begin
      a_cycles_range_r7: assert (addr_cycles_o >= 3'd3 && addr_cycles_o <= 3'd6)
        else $error("address cycle count out of range");
    end
  end

endmodule

// File: rtl/nand_probe_seq.sv
module nand_probe_seq
  import nand_probe_pkg::*;
#(
  parameter int unsigned READY_TIMEOUT = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       wide_bus_i,
  input  logic       rb_ni,
  input  logic [15:0] io_i,
  input  logic       known_i,
  input  logic       need_ext_i,
  input  logic       page_bad_i,
  output logic       cle_o,
  output logic       ale_o,
  output logic       re_o,
  output logic [7:0] io_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       fail_o,
  output err_e       err_code_o,
  output logic [7:0] maker_o,
  output logic [7:0] dev_o,
  output logic [23:0] ext_o
);
  localparam int unsigned CNT_W = $clog2(READY_TIMEOUT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_CMD, S_RST_WAIT, S_ID_CMD, S_ID_ADDR,
    S_RD_MAKER, S_RD_DEV, S_DECIDE, S_RD_X3, S_RD_X4, S_RD_X5
  } state_e;

  state_e           state_q;
  logic [CNT_W-1:0] wait_cnt_q;

  always_comb begin
    cle_o  = (state_q == S_RST_CMD) || (state_q == S_ID_CMD);
    ale_o  = (state_q == S_ID_ADDR);
    re_o   = (state_q inside {S_RD_MAKER, S_RD_DEV, S_RD_X3, S_RD_X4, S_RD_X5});
    io_o   = (state_q == S_RST_CMD) ? CMD_RESET :
             (state_q == S_ID_CMD)  ? CMD_READ_ID : 8'h00;
    busy_o = (state_q != S_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      wait_cnt_q <= '0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
      err_code_o <= ERR_NONE;
      maker_o    <= '0;
      dev_o      <= '0;
      ext_o      <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q    <= S_RST_CMD;
          err_code_o <= ERR_NONE;
          maker_o    <= '0;
          dev_o      <= '0;
          ext_o      <= '0;
        end
        S_RST_CMD: begin
          state_q    <= S_RST_WAIT;
          wait_cnt_q <= '0;
        end
        S_RST_WAIT: begin
          if (wait_cnt_q != '0 && rb_ni) state_q <= S_ID_CMD;
          else if (wait_cnt_q == CNT_W'(READY_TIMEOUT)) begin
            state_q    <= S_IDLE;
            fail_o     <= 1'b1;
            err_code_o <= ERR_TIMEOUT;
          end else wait_cnt_q <= wait_cnt_q + 1'b1;
        end
        S_ID_CMD:  state_q <= S_ID_ADDR;
        S_ID_ADDR: state_q <= S_RD_MAKER;
        S_RD_MAKER: begin
          maker_o <= io_i[7:0];
          state_q <= S_RD_DEV;
        end
        S_RD_DEV: begin
          dev_o   <= io_i[7:0];
          state_q <= S_DECIDE;
        end
        S_DECIDE: begin
          if (!known_i) begin
            state_q <= S_IDLE; fail_o <= 1'b1; err_code_o <= ERR_UNKNOWN;
          end else if (need_ext_i) begin
            state_q <= S_RD_X3;
          end else if (page_bad_i) begin
            state_q <= S_IDLE; fail_o <= 1'b1; err_code_o <= ERR_PAGE;
          end else begin
            state_q <= S_IDLE; done_o <= 1'b1;
          end
        end
        S_RD_X3: begin
          ext_o[7:0] <= io_i[7:0];
          state_q    <= S_RD_X4;
        end
        S_RD_X4: begin
          ext_o[15:8] <= io_i[7:0];
          state_q     <= S_RD_X5;
        end
        S_RD_X5: begin
          ext_o[23:16] <= wide_bus_i ? io_i[15:8] : io_i[7:0];
          state_q      <= S_IDLE;
          done_o       <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_one_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cle_o, ale_o, re_o}));
  p_addr_after_id_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cle_o && io_o == CMD_READ_ID) |=> (ale_o && io_o == 8'h00));
  p_read_after_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> re_o);
  p_ready_before_id_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cle_o && io_o == CMD_READ_ID) |-> $past(rb_ni));
  p_single_outcome_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

endmodule

// File: rtl/nand_id_probe.sv
module nand_id_probe
  import nand_probe_pkg::*;
#(
  parameter int unsigned READY_TIMEOUT = 64,
  parameter int unsigned PAGE_W        = 14,
  parameter int unsigned ERASE_W       = 10,
  parameter int unsigned BLK_W         = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               wide_bus_i,
  input  logic               rb_ni,
  input  logic [15:0]        io_i,
  output logic               cle_o,
  output logic               ale_o,
  output logic               re_o,
  output logic [7:0]         io_o,
  output logic               busy_o,
  output logic               valid_o,
  output logic               err_o,
  output logic [1:0]         err_code_o,
  output logic [7:0]         maker_id_o,
  output logic               maker_known_o,
  output logic [7:0]         dev_id_o,
  output logic [23:0]        ext_id_o,
  output logic               bus16_o,
  output logic [PAGE_W-1:0]  page_size_o,
  output logic [ERASE_W-1:0] erase_kib_o,
  output logic [2:0]         addr_cycles_o,
  output logic [BLK_W-1:0]   block_count_o
);
  logic             known, need_ext, page_bad, wide, done, fail;
  logic [3:0]       page_lg2, erase_lg2;
  logic [2:0]       cycles;
  logic [BLK_W-1:0] blocks;
  err_e             code;

  nand_probe_seq #(.READY_TIMEOUT(READY_TIMEOUT)) u_seq (
    .clk_i, .rst_ni, .start_i, .wide_bus_i, .rb_ni, .io_i,
    .known_i(known), .need_ext_i(need_ext), .page_bad_i(page_bad),
    .cle_o, .ale_o, .re_o, .io_o, .busy_o,
    .done_o(done), .fail_o(fail), .err_code_o(code),
    .maker_o(maker_id_o), .dev_o(dev_id_o), .ext_o(ext_id_o)
  );

  nand_geom_calc #(.BLK_W(BLK_W)) u_geom (
    .dev_id_i(dev_id_o), .id4_i(ext_id_o[15:8]),
    .known_o(known), .need_ext_o(need_ext), .page_bad_o(page_bad), .wide_o(wide),
    .page_lg2_o(page_lg2), .erase_lg2_o(erase_lg2),
    .addr_cycles_o(cycles), .block_count_o(blocks)
  );

  assign err_code_o = code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o       <= 1'b0;
      err_o         <= 1'b0;
      maker_known_o <= 1'b0;
      bus16_o       <= 1'b0;
      page_size_o   <= '0;
      erase_kib_o   <= '0;
      addr_cycles_o <= '0;
      block_count_o <= '0;
    end else if (start_i && !busy_o) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else if (done) begin
      valid_o       <= 1'b1;
      maker_known_o <= maker_known(maker_id_o);
      bus16_o       <= wide;
      page_size_o   <= PAGE_W'(1) << page_lg2;
      erase_kib_o   <= ERASE_W'(1) << erase_lg2;
      addr_cycles_o <= cycles;
      block_count_o <= blocks;
    end else if (fail) begin
      err_o <= 1'b1;
    end
  end

  p_flags_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));
  p_no_small_page_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> page_size_o >= PAGE_W'(512));
  p_err_coded_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_code_o != 2'd0);

endmodule

// File: tb/tb_nand_id_probe.sv
module tb_nand_id_probe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wide_bus = 1'b0, rb_n = 1'b1;
  logic [15:0] io_in = '0;
  logic cle, ale, re, busy, valid, err, maker_known, bus16;
  logic [7:0] io_out, maker_id, dev_id;
  logic [1:0] err_code;
  logic [23:0] ext_id;
  logic [13:0] page_size;
  logic [9:0] erase_kib;
  logic [2:0] addr_cycles;
  logic [19:0] block_count;

  always #4 clk = ~clk;

  nand_id_probe dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wide_bus_i(wide_bus), .rb_ni(rb_n),
    .io_i(io_in), .cle_o(cle), .ale_o(ale), .re_o(re), .io_o(io_out), .busy_o(busy),
    .valid_o(valid), .err_o(err), .err_code_o(err_code), .maker_id_o(maker_id),
    .maker_known_o(maker_known), .dev_id_o(dev_id), .ext_id_o(ext_id), .bus16_o(bus16),
    .page_size_o(page_size), .erase_kib_o(erase_kib), .addr_cycles_o(addr_cycles),
    .block_count_o(block_count)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // device model, driven at falling edges
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] words [5];
  bit never_ready = 0;
  int busy_left = 0, rd_idx = 0, re_count = 0, cmd_n = 0, ale_n = 0, last_re_cyc = 0;
  logic [7:0] cmd_log [4];
  logic [7:0] ale_byte = '0;

  always @(negedge clk) begin
    if (!rb_n && !never_ready) begin
      if (busy_left == 0) rb_n = 1'b1;
      else busy_left--;
    end
    if (cle) begin
      if (cmd_n < 4) cmd_log[cmd_n] = io_out;
      cmd_n++;
      if (io_out == 8'hFF) begin rb_n = 1'b0; busy_left = 5; end
      if (io_out == 8'h90) rd_idx = 0;
    end
    if (ale) begin ale_n++; ale_byte = io_out; end
    if (re) begin
      io_in = (rd_idx < 5) ? words[rd_idx] : 16'h0;
      rd_idx++; re_count++; last_re_cyc = cyc;
    end
  end

  typedef struct {
    string name; bit e; int code; int maker; bit mk; int dev; int ext;
    bit b16; int page; int erase; int cyc_n; int blocks; int lat;
  } exp_t;
  exp_t sb_q[$];

  // monitor: compares the first cycle in which a flag is seen
  initial begin
    forever begin
      @(negedge clk);
      if ((valid || err) && sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        chk({x.name, " R13 err flag"}, err, x.e);
        chk({x.name, " R13 valid flag"}, valid, !x.e);
        chk({x.name, " R6 R10 R11 err code"}, err_code, x.code);
        if (x.lat > 0) chk({x.name, " R13 latency"}, cyc - last_re_cyc, x.lat);
        if (!x.e) begin
          chk({x.name, " R2 maker"}, maker_id, x.maker);
          chk({x.name, " R10 maker known"}, maker_known, x.mk);
          chk({x.name, " R2 dev"}, dev_id, x.dev);
          chk({x.name, " R3 ext bytes"}, ext_id, x.ext);
          chk({x.name, " R12 bus16"}, bus16, x.b16);
          chk({x.name, " R4 page"}, page_size, x.page);
          chk({x.name, " R5 erase"}, erase_kib, x.erase);
          chk({x.name, " R7 R8 cycles"}, addr_cycles, x.cyc_n);
          chk({x.name, " R9 blocks"}, block_count, x.blocks);
        end
      end
    end
  end

  task automatic run_case(input exp_t x, input bit wb, input bit nr,
                          input logic [15:0] w0, w1, w2, w3, w4, input int reads);
    @(negedge clk);
    words[0] = w0; words[1] = w1; words[2] = w2; words[3] = w3; words[4] = w4;
    wide_bus = wb; never_ready = nr;
    re_count = 0; cmd_n = 0; ale_n = 0; ale_byte = 8'hAA;
    sb_q.push_back(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
    // R1 bus order and R3 strobe count
    chk({x.name, " R1 first cmd"}, cmd_log[0], 8'hFF);
    if (nr) begin
      chk({x.name, " R11 no id cmd"}, cmd_n, 1);
    end else begin
      chk({x.name, " R1 id cmd"}, cmd_log[1], 8'h90);
      chk({x.name, " R1 cmd count"}, cmd_n, 2);
      chk({x.name, " R1 addr cycles"}, ale_n, 1);
      chk({x.name, " R1 addr byte"}, ale_byte, 8'h00);
    end
    chk({x.name, " R3 read strobes"}, re_count, reads);
    rb_n = 1'b1; never_ready = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("reset R13 valid", valid, 0);
    chk("reset R13 err", err, 0);
    chk("reset R1 strobes", {cle, ale, re}, 0);
    chk("reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    //                name     e code maker mk dev ext        b16 page  erase cyc blocks lat
    run_case('{"small16", 0, 0, 8'hEC, 1, 8'h73, 0, 0, 512, 16, 3, 1024, 3}, 0, 0,
             16'h00EC, 16'h0073, 0, 0, 0, 2);
    run_case('{"wide64", 0, 0, 8'h98, 1, 8'h56, 0, 1, 512, 16, 4, 4096, 3}, 1, 0,
             16'hA598, 16'h3C56, 0, 0, 0, 2);
    run_case('{"ext128", 0, 0, 8'h77, 0, 8'hF1, 24'h4415C1, 0, 2048, 128, 4, 1024, 2}, 0, 0,
             16'h0077, 16'h00F1, 16'h00C1, 16'h0015, 16'hEE44, 5);
    run_case('{"ext256w", 0, 0, 8'hAD, 1, 8'hDA, 24'h992A01, 0, 4096, 256, 5, 1024, 2}, 1, 0,
             16'h11AD, 16'h22DA, 16'h3301, 16'h442A, 16'h9955, 5);
    run_case('{"small4", 0, 0, 8'h20, 1, 8'h6B, 0, 0, 512, 8, 3, 512, 3}, 0, 0,
             16'h0020, 16'h006B, 0, 0, 0, 2);
    run_case('{"page256", 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3}, 0, 0,
             16'h0098, 16'h006E, 0, 0, 0, 2);
    run_case('{"unknown", 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3}, 0, 0,
             16'h00EC, 16'h0012, 0, 0, 0, 2);
    run_case('{"timeout", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, 0, 1,
             0, 0, 0, 0, 0, 0);
    run_case('{"recover", 0, 0, 8'h04, 1, 8'h75, 0, 0, 512, 16, 3, 2048, 3}, 0, 0,
             16'h0004, 16'h0075, 0, 0, 0, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule